// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block picks the next program counter for the control-transfer instructions of a small 16-bit load/store processor. It also produces the return-link value that such instructions save in register R7. Each cycle that the pipeline raises `issue`, the block decodes the instruction word. Its inputs are the instruction word, the program counter that has already been incremented past that instruction, the condition flags, and one register-file read port. From these it resolves the target. Every PC-relative target is the incremented PC plus a sign-extended offset taken from the instruction word.

Conditional branches, calls, register jumps and the pass-through of every other opcode resolve in the same cycle as `issue`. A system call (trap) takes two cycles. In the first cycle the block requests a read of a 256-entry vector table at a zero-extended address. In the second cycle it loads the word that comes back as the new PC and writes the link value, which it captured during the first cycle. The register-file read address is driven directly from the instruction's base-register field.

Top module: `npc_ctrl_unit`

## Requirements
- R1: While `rst_n` is low, `pc_load`, `link_we`, `vec_rd` and `trap_done` are all 0, whatever `issue` does.
- R2: With opcode `ir[15:12]`=0000, a branch is taken when a selected flag is set. Bit 11 selects N (`flags[2]`), bit 10 selects Z (`flags[1]`) and bit 9 selects P (`flags[0]`). A taken branch gives `next_pc` = `pc_inc` + sign-extended `ir[8:0]`; a branch not taken gives `next_pc` = `pc_inc`. `pc_load` is 1 in the issue cycle either way, and `link_we` is 0.
- R3: A branch whose three select bits are 000 is never taken. A branch whose three select bits are 111 is always taken.
- R4: With opcode 0100 and `ir[11]`=1, `next_pc` = `pc_inc` + sign-extended `ir[10:0]`.
- R5: With opcode 0100 and `ir[11]`=0, `next_pc` = `reg_data`.
- R6: With opcode 1100, `next_pc` = `reg_data` and `link_we` is 0. This holds for the return form too, whose base field is 7.
- R7: Every opcode-0100 instruction raises `link_we` in its issue cycle with `link_data` = `pc_inc`.
- R8: With opcode 1111, the issue cycle raises `vec_rd` with `vec_addr` = `{8'h00, ir[7:0]}`, and `pc_load` and `link_we` stay 0.
- R9: The cycle after a trap request, `trap_done`, `pc_load` and `link_we` are 1. In that cycle `next_pc` = `vec_data` and `link_data` = the `pc_inc` of the request cycle.
- R10: Any other opcode gives `pc_load`=1 with `next_pc` = `pc_inc` and `link_we`=0.
- R11: An `issue` in the trap-completion cycle is ignored: no `vec_rd` is raised, and the completion outputs of R9 are unchanged.
- R12: `reg_sel` always equals `ir[8:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| ir | input | 16 | Instruction word |
| pc_inc | input | DATA_W | PC already advanced past `ir` |
| flags | input | 3 | Condition flags {N,Z,P} |
| reg_sel | output | 3 | Register-file read address (`ir[8:6]`) |
| reg_data | input | DATA_W | Register-file read data for `reg_sel` |
| vec_rd | output | 1 | Vector-table read request |
| vec_addr | output | DATA_W | Zero-extended vector-table address |
| vec_data | input | DATA_W | Vector-table word, valid the cycle after `vec_rd` |
| pc_load | output | 1 | `next_pc` is valid and must be loaded |
| next_pc | output | DATA_W | Resolved next program counter |
| link_we | output | 1 | Write `link_data` into R7 |
| link_data | output | DATA_W | Return-link value |
| trap_done | output | 1 | Second step of a trap |

## Verification
The assertions take for granted that the table word on `vec_data` is valid exactly one cycle after `vec_rd`, and that `reg_data` follows `reg_sel` within the same cycle. The bench meets the first condition by driving `vec_data` in every cycle and by comparing `next_pc` with the value present during completion. It meets the second by treating `reg_data` as a free input held steady for the cycle. The flags are always driven one-hot, as a flag register would hold them. The bench also deliberately raises `issue` during trap completion and during reset, so that the rules for ignoring `issue` are exercised rather than assumed.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int IR_W       = 16;
   localparam int BR_OFF_W   = 9;
   localparam int CALL_OFF_W = 11;
   localparam int VEC_W      = 8;
   localparam int REG_AW     = 3;
   localparam int FLAG_W     = 3;

   localparam logic [3:0] OPC_BRANCH = 4'b0000;
   localparam logic [3:0] OPC_CALL   = 4'b0100;
   localparam logic [3:0] OPC_JUMP   = 4'b1100;
   localparam logic [3:0] OPC_TRAP   = 4'b1111;

   typedef enum logic [2:0] {
      XFER_SEQ,
      XFER_BRANCH,
      XFER_CALL_REL,
      XFER_CALL_REG,
      XFER_JUMP,
      XFER_TRAP
   } xfer_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [IR_W-1:0] ir,
   output xfer_kind_e      kind
);
   logic [3:0] opc;
   assign opc = ir[IR_W-1 -: 4];

   always_comb begin
      unique case (opc)
         OPC_BRANCH: kind = XFER_BRANCH;
         OPC_CALL:   kind = ir[CALL_OFF_W] ? XFER_CALL_REL : XFER_CALL_REG;
         OPC_JUMP:   kind = XFER_JUMP;
         OPC_TRAP:   kind = XFER_TRAP;
         default:    kind = XFER_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
(
   input  logic [IR_W-1:0]   ir,
   input  logic [FLAG_W-1:0] flags,
   output logic              take
);
   logic [FLAG_W-1:0] sel;
   assign sel  = ir[BR_OFF_W + FLAG_W - 1 -: FLAG_W];
   assign take = |(sel & flags);
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
   import npc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [IR_W-1:0]   ir,
   input  logic [DATA_W-1:0] pc_inc,
   input  logic [DATA_W-1:0] reg_data,
   input  xfer_kind_e        kind,
   input  logic              take,
   output logic [DATA_W-1:0] target
);
   localparam int BR_EXT   = DATA_W - BR_OFF_W;
   localparam int CALL_EXT = DATA_W - CALL_OFF_W;

   logic [DATA_W-1:0] off_br, off_call;
   logic [DATA_W-1:0] sum_br, sum_call;

   assign off_br   = {{BR_EXT{ir[BR_OFF_W-1]}},     ir[BR_OFF_W-1:0]};
   assign off_call = {{CALL_EXT{ir[CALL_OFF_W-1]}}, ir[CALL_OFF_W-1:0]};

   generate
      if (SHARED_ADDER) begin : g_one_adder
         logic [DATA_W-1:0] off_sel, sum_any;
         assign off_sel  = (kind == XFER_CALL_REL) ? off_call : off_br;
         assign sum_any  = pc_inc + off_sel;
         assign sum_br   = sum_any;
         assign sum_call = sum_any;
      end else begin : g_two_adders
         assign sum_br   = pc_inc + off_br;
         assign sum_call = pc_inc + off_call;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         XFER_BRANCH:   target = take ? sum_br : pc_inc;
         XFER_CALL_REL: target = sum_call;
         XFER_CALL_REG,
         XFER_JUMP:     target = reg_data;
         default:       target = pc_inc;
      endcase
   end
endmodule

// File: rtl/npc_trap_seq.sv
module npc_trap_seq
   import npc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VEC_W-1:0]  vec_idx,
   input  logic [DATA_W-1:0] pc_inc,
   output logic              req,
   output logic [DATA_W-1:0] req_addr,
   output logic              busy,
   output logic [DATA_W-1:0] saved_link
);
   logic              busy_q;
   logic [DATA_W-1:0] link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         link_q <= '0;
      end else begin
         busy_q <= start;
         if (start) link_q <= pc_inc;
      end
   end

   assign req        = start;
   assign req_addr   = {{(DATA_W-VEC_W){1'b0}}, vec_idx};
   assign busy       = busy_q;
   assign saved_link = link_q;
endmodule

// File: rtl/npc_ctrl_unit.sv
module npc_ctrl_unit
   import npc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [15:0]       ir,
   input  logic [DATA_W-1:0] pc_inc,
   input  logic [2:0]        flags,
   output logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_data,
   output logic              vec_rd,
   output logic [DATA_W-1:0] vec_addr,
   input  logic [DATA_W-1:0] vec_data,
   output logic              pc_load,
   output logic [DATA_W-1:0] next_pc,
   output logic              link_we,
   output logic [DATA_W-1:0] link_data,
   output logic              trap_done
);
   initial begin
      assert (DATA_W >= IR_W) else $error("DATA_W must cover the instruction width");
      assert (DATA_W > VEC_W) else $error("DATA_W must exceed the vector width");
   end

   xfer_kind_e        kind;
   logic              take, busy, eff_issue, trap_start, is_call;
   logic [DATA_W-1:0] target, saved_link;

   npc_decode u_dec (.ir(ir), .kind(kind));

   npc_cond_eval u_cond (.ir(ir), .flags(flags), .take(take));

   npc_target_gen #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_tgt (
      .ir(ir), .pc_inc(pc_inc), .reg_data(reg_data),
      .kind(kind), .take(take), .target(target)
   );

   assign eff_issue  = issue & rst_n & ~busy;
   assign trap_start = eff_issue & (kind == XFER_TRAP);
   assign is_call    = (kind == XFER_CALL_REL) | (kind == XFER_CALL_REG);

   npc_trap_seq #(.DATA_W(DATA_W)) u_trap (
      .clk(clk), .rst_n(rst_n), .start(trap_start),
      .vec_idx(ir[VEC_W-1:0]), .pc_inc(pc_inc),
      .req(vec_rd), .req_addr(vec_addr),
      .busy(busy), .saved_link(saved_link)
   );

   assign reg_sel   = ir[BR_OFF_W-1 -: REG_AW];
   assign pc_load   = busy | (eff_issue & (kind != XFER_TRAP));
   assign next_pc   = busy ? vec_data : target;
   assign link_we   = busy | (eff_issue & is_call);
   assign link_data = busy ? saved_link : pc_inc;
   assign trap_done = busy;
endmodule

// File: rtl/npc_ctrl_unit_chk.sv
module npc_ctrl_unit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic [15:0]       ir,
   input logic [DATA_W-1:0] pc_inc,
   input logic [DATA_W-1:0] vec_data,
   input logic              vec_rd,
   input logic [DATA_W-1:0] vec_addr,
   input logic              pc_load,
   input logic [DATA_W-1:0] next_pc,
   input logic              link_we,
   input logic [DATA_W-1:0] link_data,
   input logic              trap_done
);
   always @(posedge clk) begin
      if (!rst_n)
         p_reset_quiet_r1: assert (!pc_load && !link_we && !vec_rd && !trap_done);
   end

   p_two_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> trap_done);

   p_vec_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |-> (vec_addr == DATA_W'(ir[7:0])) && !pc_load && !link_we);

   p_done_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_done |-> pc_load && link_we && (next_pc == vec_data));

   p_done_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> (link_data == $past(pc_inc)));

   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_done |-> !vec_rd);

   p_ret_nolink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !trap_done && ir[15:12] == 4'b1100) |-> pc_load && !link_we);

   p_call_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !trap_done && ir[15:12] == 4'b0100) |-> link_we && (link_data == pc_inc));
endmodule

bind npc_ctrl_unit npc_ctrl_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .issue(issue), .ir(ir), .pc_inc(pc_inc),
   .vec_data(vec_data), .vec_rd(vec_rd), .vec_addr(vec_addr),
   .pc_load(pc_load), .next_pc(next_pc), .link_we(link_we),
   .link_data(link_data), .trap_done(trap_done)
);

// File: tb/npc_ctrl_unit_test.sv
module npc_ctrl_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [15:0] ir = '0, pc_inc = '0, reg_data = '0, vec_data = '0;
   logic [2:0]  flags = 3'b010;
   logic [2:0]  reg_sel;
   logic        vec_rd, pc_load, link_we, trap_done;
   logic [15:0] vec_addr, next_pc, link_data;

   int n_vec = 0, n_bad = 0;
   bit m_busy = 1'b0;
   logic [15:0] m_link = '0;

   always #5 clk = ~clk;

   npc_ctrl_unit uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .ir(ir), .pc_inc(pc_inc),
      .flags(flags), .reg_sel(reg_sel), .reg_data(reg_data),
      .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
      .pc_load(pc_load), .next_pc(next_pc), .link_we(link_we),
      .link_data(link_data), .trap_done(trap_done)
   );

   function automatic string req_tag(input logic [15:0] i, input logic iss);
      if (!rst_n) return "R1";
      if (m_busy) return iss ? "R11" : "R9";
      if (!iss) return "R10";
      case (i[15:12])
         4'b0000: return (i[11:9] == 3'b000 || i[11:9] == 3'b111) ? "R3" : "R2";
         4'b0100: return i[11] ? "R4" : "R5";
         4'b1100: return "R6";
         4'b1111: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic fail(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
   endtask

   task automatic apply(input logic iss, input logic [15:0] i, input logic [15:0] pc,
                        input logic [15:0] rd, input logic [15:0] vd, input logic [2:0] f);
      bit eff, e_load, e_vrd, e_lwe, taken, bad;
      logic [15:0] e_npc, e_ldata;
      string tag;
      @(negedge clk);
      issue = iss; ir = i; pc_inc = pc; reg_data = rd; vec_data = vd; flags = f;
      #2;
      eff    = rst_n && iss && !m_busy;
      e_vrd  = eff && (i[15:12] == 4'b1111);
      e_load = m_busy || (eff && i[15:12] != 4'b1111);
      e_lwe  = m_busy || (eff && i[15:12] == 4'b0100);
      e_ldata = m_busy ? m_link : pc;
      taken  = (i[11] && f[2]) || (i[10] && f[1]) || (i[9] && f[0]);
      if (m_busy) e_npc = vd;
      else case (i[15:12])
         4'b0000: e_npc = taken ? pc + 16'($signed(i[8:0])) : pc;
         4'b0100: e_npc = i[11] ? pc + 16'($signed(i[10:0])) : rd;
         4'b1100: e_npc = rd;
         default: e_npc = pc;
      endcase
      tag = req_tag(i, iss);
      bad = 1'b0;
      n_vec++;
      if (reg_sel !== i[8:6]) begin bad = 1; fail("R12", "reg_sel", 16'(reg_sel), 16'(i[8:6])); end
      if (pc_load !== e_load) begin bad = 1; fail(tag, "pc_load", 16'(pc_load), 16'(e_load)); end
      if (vec_rd !== e_vrd) begin bad = 1; fail(tag, "vec_rd", 16'(vec_rd), 16'(e_vrd)); end
      if (trap_done !== (rst_n && m_busy)) begin bad = 1; fail(tag, "trap_done", 16'(trap_done), 16'(m_busy)); end
      if (link_we !== e_lwe) begin bad = 1; fail(m_busy ? tag : "R7", "link_we", 16'(link_we), 16'(e_lwe)); end
      if (e_load && next_pc !== e_npc) begin bad = 1; fail(tag, "next_pc", next_pc, e_npc); end
      if (e_lwe && link_data !== e_ldata) begin bad = 1; fail(m_busy ? "R9" : "R7", "link_data", link_data, e_ldata); end
      if (e_vrd && vec_addr !== {8'h00, i[7:0]}) begin bad = 1; fail("R8", "vec_addr", vec_addr, {8'h00, i[7:0]}); end
      if (bad) n_bad++;
      if (e_vrd) m_link = pc;
      m_busy = e_vrd;
   endtask

   function automatic logic [2:0] rnd_flags();
      return 3'b001 << ($urandom % 3);
   endfunction

   initial begin
      #1_900_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset holds everything quiet, even with issue raised
      apply(1, 16'h0E05, 16'h3001, 16'h0, 16'h0, 3'b100);
      apply(1, 16'hF025, 16'h3002, 16'h0, 16'h0, 3'b010);
      apply(1, 16'h4801, 16'h3003, 16'h0, 16'h0, 3'b001);
      @(negedge clk); rst_n = 1'b1;
      // R2: BR np with N set skips one instruction
      apply(1, 16'h0A01, 16'h3005, 16'h0, 16'h0, 3'b100);
      // R2: BR np with Z set falls through
      apply(1, 16'h0A01, 16'h3005, 16'h0, 16'h0, 3'b010);
      // R2: negative offset
      apply(1, 16'h05F8, 16'h3010, 16'h0, 16'h0, 3'b010);
      // R3: mask 000 never, 111 always
      apply(1, 16'h0120, 16'h3020, 16'h0, 16'h0, 3'b100);
      apply(1, 16'h0F80, 16'h3020, 16'h0, 16'h0, 3'b001);
      // R4 R7: PC-relative call with negative offset
      apply(1, 16'h4C00, 16'h3100, 16'h0, 16'h0, 3'b001);
      // R5 R7: register call via R3
      apply(1, 16'h40C0, 16'h3101, 16'h5A5A, 16'h0, 3'b010);
      // R6: return through R7, no link
      apply(1, 16'hC1C0, 16'h0440, 16'h3102, 16'h0, 3'b010);
      // R8 then R9 with R11: trap x21, issue held during completion
      apply(1, 16'hF021, 16'h3200, 16'h0, 16'h0, 3'b100);
      apply(1, 16'hF025, 16'h3201, 16'h0, 16'h0430, 3'b100);
      // R10: an arithmetic opcode passes through
      apply(1, 16'h1234, 16'h3300, 16'h0, 16'h0, 3'b001);
      apply(0, 16'h0E05, 16'h3301, 16'h0, 16'h0, 3'b001);
      // trap at top of table, idle completion
      apply(1, 16'hF0FF, 16'hFFFF, 16'h0, 16'h0, 3'b001);
      apply(0, 16'h0000, 16'h0000, 16'h0, 16'h1234, 3'b001);
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] i;
         i = 16'($urandom);
         case ($urandom % 6)
            0: i[15:12] = 4'b0000;
            1: i[15:12] = 4'b0100;
            2: i[15:12] = 4'b1100;
            3: i[15:12] = 4'b1111;
            default: ;
         endcase
         apply(($urandom % 5) != 0, i, 16'($urandom), 16'($urandom), 16'($urandom), rnd_flags());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule